// File: doc/BRIEF.md
# Match-Capture Timer Counter

A general purpose timer/counter for a chip's peripheral region. A main counter advances once per prescaled clock tick in timer mode. In counter mode it advances on chosen transitions of an external input instead. Four compare channels watch the counter. On a hit, each channel can let counting go on, halt it, or send it back to zero. Each channel also drives its own output pin: it can leave the pin alone, drive it low, drive it high, or invert it. A channel can also raise an interrupt flag and a one-cycle DMA request.

Four capture inputs pass through synchronisers. On a selected edge, each one snapshots the counter. One capture channel can be named to zero both the counter and the prescaler on its edge. A pulse width is measured by clearing on the leading edge and capturing on the trailing edge. Software reaches the block through a flat register file. Writes take effect in the clock cycle of the write, and reads are combinational.

Top module: `mc_timer`

## Requirements
- R1: Timer mode (control bit 0 = 1, bit 1 = 0) with prescale limit P (address 1) increments the counter (address 2) once every P+1 clocks. The first increment comes P+1 clocks after the write that sets control bit 0. A write to address 1 or address 2 restarts the prescale phase, and a write to address 2 also loads the counter.
- R2: Counter mode (control bits 1:0 = 2'b11) increments the counter once per selected edge of `count_in`. Control bits 3:2 select the edge: 01 rising, 10 falling, 11 both. The input is synchronised by two flops, and the count appears three clocks after the pin changes.
- R3: Match channel n compares its value (address 8+n) with the counter on each tick. A hit is a tick with the counter equal to that value. Action bits [1:0] of byte n of address 3 choose what the hit does. 00: the counter increments. 01: the counter holds and control bit 0 clears. 10: the counter becomes 0 in place of the increment.
- R4: Bits [3:2] of byte n of address 3 set the effect of a hit on `match_out[n]`. 00 leaves it unchanged, 01 drives it low, 10 drives it high, and 11 inverts it. Address 6 reads and writes the four pin states directly.
- R5: Capture channel n has edge bits [1:0] in byte n of address 4, with 01 rising, 10 falling and 11 both. It loads the counter value into address 12+n on the third clock after `cap_in[n]` changes. With edge bits 00, or with the edge not selected, the value is left as it was.
- R6: Flags at address 5 are sticky. Bits 0-3 are set by hits on channels whose byte bit 4 in address 3 is 1. Bits 4-7 are set by captures whose byte bit 2 in address 4 is 1. Writing 1 to a bit clears it, and writing 0 leaves it. `irq` is high while any flag is set.
- R7: A hit on channel n with byte bit 5 of address 3 set drives `dma_req[n]` high for exactly the one clock after the hit edge.
- R8: With control bit 4 set, a capture on the channel named by control bits 6:5 zeroes the counter and the prescaler. With prescale 0, clearing on a rising edge and capturing on the falling edge of a W-clock pulse yields W-1. With prescale 1 and a W-clock pulse, the result is (W-1)/2 rounded down.
- R9: After reset the counter, all registers, `match_out`, `dma_req` and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for write and read |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` |
| count_in | input | 1 | External count input for counter mode |
| cap_in | input | NCAP | Capture inputs |
| match_out | output | NMATCH | Match output pins |
| dma_req | output | NMATCH | One-cycle DMA request per match channel |
| irq | output | 1 | Interrupt, high while any flag is set |

## Verification
The bench attacks the hit semantics at their edges. A reset hit must produce zero in place of the next increment; an off-by-one design would reach the match value plus one, or clear a cycle early. A stop hit must freeze the counter on the match value and drop the run bit; a design that stops late would read one higher. Pulse-width measurement with prescale 0 and prescale 1 exposes a clear that forgets the prescaler phase or captures the counter after it is cleared. A falling-only capture channel driven by a rising edge, and a zero written to the flag register, check that the block ignores what it should; a design getting these wrong would change a stored capture or drop a sticky flag.

// File: rtl/mct_pkg.sv
package mct_pkg;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int LANE = 8;
  localparam int CTRL_W = 7;

  localparam logic [AW-1:0] A_CTRL  = 4'h0;
  localparam logic [AW-1:0] A_PRESC = 4'h1;
  localparam logic [AW-1:0] A_COUNT = 4'h2;
  localparam logic [AW-1:0] A_MCFG  = 4'h3;
  localparam logic [AW-1:0] A_CCFG  = 4'h4;
  localparam logic [AW-1:0] A_FLAG  = 4'h5;
  localparam logic [AW-1:0] A_PINS  = 4'h6;
  localparam logic [AW-1:0] A_MVAL  = 4'h8;
  localparam logic [AW-1:0] A_CVAL  = 4'hC;

  // control register bit positions
  localparam int C_RUN = 0;
  localparam int C_EXT = 1;
  localparam int C_EDGE = 2;
  localparam int C_CLREN = 4;
  localparam int C_CLRSEL = 5;

  // field offsets inside one lane of the match / capture config
  localparam int MF_ACT = 0;
  localparam int MF_PIN = 2;
  localparam int MF_IRQ = 4;
  localparam int MF_DMA = 5;
  localparam int CF_EDGE = 0;
  localparam int CF_IRQ = 2;

  typedef enum logic [1:0] {
    CA_CONT  = 2'd0,
    CA_STOP  = 2'd1,
    CA_RESET = 2'd2
  } cnt_act_e;

  typedef enum logic [1:0] {
    PA_NONE   = 2'd0,
    PA_LOW    = 2'd1,
    PA_HIGH   = 2'd2,
    PA_TOGGLE = 2'd3
  } pin_act_e;
endpackage

// File: rtl/mct_edge.sv
module mct_edge #(
  parameter int N = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   din,
  input  logic [2*N-1:0] sel,
  output logic [N-1:0]   evt
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_det
    logic rise, fall;
    always_comb begin
      rise   = s2_q[g] & ~s3_q[g];
      fall   = ~s2_q[g] & s3_q[g];
      evt[g] = (sel[2*g] & rise) | (sel[2*g+1] & fall);
    end
  end
endmodule

// File: rtl/mct_prescale.sv
module mct_prescale #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] pcnt_q, pcnt_d;

  assign tick = en && (pcnt_q == limit);

  always_comb begin
    pcnt_d = pcnt_q;
    if (clr)       pcnt_d = '0;
    else if (tick) pcnt_d = '0;
    else if (en)   pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R1: the phase never passes the programmed limit
  assert_presc_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= limit);
endmodule

// File: rtl/mct_match_ch.sv
module mct_match_ch
  import mct_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] mval,
  input  pin_act_e     pin_act,
  input  logic         dma_en,
  input  logic         pin_wr,
  input  logic         pin_wval,
  output logic         hit,
  output logic         pin_q,
  output logic         dma_q
);
  logic pin_d, dma_d;

  assign hit = tick && (cnt == mval);

  always_comb begin
    pin_d = pin_q;
    if (pin_wr) begin
      pin_d = pin_wval;
    end else if (hit) begin
      case (pin_act)
        PA_LOW:    pin_d = 1'b0;
        PA_HIGH:   pin_d = 1'b1;
        PA_TOGGLE: pin_d = ~pin_q;
        default:   pin_d = pin_q;
      endcase
    end
    dma_d = hit && dma_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      dma_q <= 1'b0;
    end else begin
      pin_q <= pin_d;
      dma_q <= dma_d;
    end
  end

  // R4: an inverting hit flips the pin
  assert_pin_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && pin_act == PA_TOGGLE && !pin_wr) |=> (pin_q != $past(pin_q)));

  // R4: a drive-high hit leaves the pin high
  assert_pin_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && pin_act == PA_HIGH && !pin_wr) |=> pin_q);

  // R7: a request only follows a cycle where counter and compare value met
  assert_dma_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_q |-> ($past(cnt) == $past(mval)));
endmodule

// File: rtl/mc_timer.sv
module mc_timer
  import mct_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int NMATCH = 4,
  parameter int NCAP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  input  logic              count_in,
  input  logic [NCAP-1:0]   cap_in,
  output logic [NMATCH-1:0] match_out,
  output logic [NMATCH-1:0] dma_req,
  output logic              irq
);
  localparam int NFLAG = NMATCH + NCAP;
  localparam int NEDGE = NCAP + 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  // registers
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  presc_q, presc_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DW-1:0]     mcfg_q, mcfg_d;
  logic [DW-1:0]     ccfg_q, ccfg_d;
  logic [NFLAG-1:0]  flag_q, flag_d;
  logic [CNT_W-1:0]  mval_q [NMATCH];
  logic [CNT_W-1:0]  mval_d [NMATCH];
  logic [CNT_W-1:0]  cval_q [NCAP];
  logic [CNT_W-1:0]  cval_d [NCAP];

  // write decode
  logic wr_ctrl, wr_presc, wr_cnt, wr_mcfg, wr_ccfg, wr_flag, wr_pins;
  logic [NMATCH-1:0] wr_mval;
  always_comb begin
    wr_ctrl  = wr_en && (addr == A_CTRL);
    wr_presc = wr_en && (addr == A_PRESC);
    wr_cnt   = wr_en && (addr == A_COUNT);
    wr_mcfg  = wr_en && (addr == A_MCFG);
    wr_ccfg  = wr_en && (addr == A_CCFG);
    wr_flag  = wr_en && (addr == A_FLAG);
    wr_pins  = wr_en && (addr == A_PINS);
    for (int i = 0; i < NMATCH; i++)
      wr_mval[i] = wr_en && (addr == A_MVAL + AW'(i));
  end

  // edge detection for capture inputs and the count input
  logic [NEDGE-1:0]   edge_in, edge_evt;
  logic [2*NEDGE-1:0] edge_sel;
  logic [NCAP-1:0]    cap_evt;
  logic               cnt_evt;
  always_comb begin
    edge_in = {count_in, cap_in};
    for (int i = 0; i < NCAP; i++)
      edge_sel[2*i +: 2] = ccfg_q[LANE*i+CF_EDGE +: 2];
    edge_sel[2*NCAP +: 2] = ctrl_q[C_EDGE +: 2];
  end

  mct_edge #(.N(NEDGE)) u_edge (
    .clk   (clk),
    .rst_n (rst_core_n),
    .din   (edge_in),
    .sel   (edge_sel),
    .evt   (edge_evt)
  );
  assign cap_evt = edge_evt[NCAP-1:0];
  assign cnt_evt = edge_evt[NCAP];

  // tick source
  logic run, ext_mode, presc_tick, presc_clr, tick, clr_cap;
  assign run      = ctrl_q[C_RUN];
  assign ext_mode = ctrl_q[C_EXT];

  always_comb begin
    clr_cap = 1'b0;
    for (int i = 0; i < NCAP; i++)
      if (ctrl_q[C_CLREN] && ctrl_q[C_CLRSEL +: 2] == 2'(i) && cap_evt[i])
        clr_cap = 1'b1;
  end
  assign presc_clr = clr_cap || wr_cnt || wr_presc;

  mct_prescale #(.W(CNT_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_core_n),
    .en    (run && !ext_mode),
    .clr   (presc_clr),
    .limit (presc_q),
    .tick  (presc_tick)
  );
  assign tick = ext_mode ? (run && cnt_evt) : presc_tick;

  // match channels
  logic [NMATCH-1:0] hit, rst_m, stop_m, mirq, pin_q, dma_q;
  for (genvar g = 0; g < NMATCH; g++) begin : g_match
    logic [1:0] act;
    pin_act_e   pact;
    assign act      = mcfg_q[LANE*g+MF_ACT +: 2];
    assign pact     = pin_act_e'(mcfg_q[LANE*g+MF_PIN +: 2]);
    assign rst_m[g]  = (act == CA_RESET);
    assign stop_m[g] = (act == CA_STOP);
    assign mirq[g]   = mcfg_q[LANE*g+MF_IRQ];

    mct_match_ch #(.W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .tick     (tick),
      .cnt      (cnt_q),
      .mval     (mval_q[g]),
      .pin_act  (pact),
      .dma_en   (mcfg_q[LANE*g+MF_DMA]),
      .pin_wr   (wr_pins),
      .pin_wval (wr_data[g]),
      .hit      (hit[g]),
      .pin_q    (pin_q[g]),
      .dma_q    (dma_q[g])
    );
  end

  logic any_rst, any_stop;
  assign any_rst  = |(hit & rst_m);
  assign any_stop = |(hit & stop_m);

  // next state
  logic [NFLAG-1:0] flag_set;
  always_comb begin
    ctrl_d  = ctrl_q;
    presc_d = presc_q;
    mcfg_d  = mcfg_q;
    ccfg_d  = ccfg_q;
    cnt_d   = cnt_q;

    if (wr_ctrl)       ctrl_d = wr_data[CTRL_W-1:0];
    else if (any_stop) ctrl_d[C_RUN] = 1'b0;
    if (wr_presc) presc_d = wr_data[CNT_W-1:0];
    if (wr_mcfg)  mcfg_d  = wr_data;
    if (wr_ccfg)  ccfg_d  = wr_data;

    if (wr_cnt)        cnt_d = wr_data[CNT_W-1:0];
    else if (clr_cap)  cnt_d = '0;
    else if (tick) begin
      if (any_rst)       cnt_d = '0;
      else if (any_stop) cnt_d = cnt_q;
      else               cnt_d = cnt_q + 1'b1;
    end

    for (int i = 0; i < NMATCH; i++) begin
      mval_d[i]   = wr_mval[i] ? wr_data[CNT_W-1:0] : mval_q[i];
      flag_set[i] = hit[i] && mirq[i];
    end
    for (int i = 0; i < NCAP; i++) begin
      cval_d[i]          = cap_evt[i] ? cnt_q : cval_q[i];
      flag_set[NMATCH+i] = cap_evt[i] && ccfg_q[LANE*i+CF_IRQ];
    end

    flag_d = flag_q;
    if (wr_flag) flag_d = flag_d & ~wr_data[NFLAG-1:0];
    flag_d = flag_d | flag_set;
  end

  // register state
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ctrl_q  <= '0;
      presc_q <= '0;
      cnt_q   <= '0;
      mcfg_q  <= '0;
      ccfg_q  <= '0;
      flag_q  <= '0;
      for (int i = 0; i < NMATCH; i++) mval_q[i] <= '0;
      for (int i = 0; i < NCAP; i++)   cval_q[i] <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      presc_q <= presc_d;
      cnt_q   <= cnt_d;
      mcfg_q  <= mcfg_d;
      ccfg_q  <= ccfg_d;
      flag_q  <= flag_d;
      for (int i = 0; i < NMATCH; i++) mval_q[i] <= mval_d[i];
      for (int i = 0; i < NCAP; i++)   cval_q[i] <= cval_d[i];
    end
  end

  // read mux
  always_comb begin
    rd_data = '0;
    case (addr)
      A_CTRL:  rd_data = DW'(ctrl_q);
      A_PRESC: rd_data = DW'(presc_q);
      A_COUNT: rd_data = DW'(cnt_q);
      A_MCFG:  rd_data = mcfg_q;
      A_CCFG:  rd_data = ccfg_q;
      A_FLAG:  rd_data = DW'(flag_q);
      A_PINS:  rd_data = DW'(pin_q);
      default: begin
        for (int i = 0; i < NMATCH; i++)
          if (addr == A_MVAL + AW'(i)) rd_data = DW'(mval_q[i]);
        for (int i = 0; i < NCAP; i++)
          if (addr == A_CVAL + AW'(i)) rd_data = DW'(cval_q[i]);
      end
    endcase
  end

  assign match_out = pin_q;
  assign dma_req   = dma_q;
  assign irq       = |flag_q;

  // R1: a plain tick moves the counter by one
  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
    (tick && !any_rst && !any_stop && !wr_cnt && !clr_cap)
      |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  // R3: a stop hit drops the run bit
  assert_stop_halts_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (any_stop && !wr_ctrl) |=> !ctrl_q[C_RUN]);

  // R6: a set flag survives until a one is written to it
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    !wr_flag |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R8: a clearing capture leaves the counter at zero
  assert_clr_cap_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (clr_cap && !wr_cnt) |=> (cnt_q == '0));
endmodule

// File: tb/mc_timer_tb.sv
`timescale 1ns/1ps
module mc_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        count_in;
  logic [3:0]  cap_in;
  logic [3:0]  match_out;
  logic [3:0]  dma_req;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] v;

  always #2 clk = ~clk;

  mc_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .count_in(count_in), .cap_in(cap_in),
    .match_out(match_out), .dma_req(dma_req), .irq(irq)
  );

  // {prescale, clocks run, expected count}
  localparam logic [31:0] VEC [6][3] = '{
    '{0, 10, 10}, '{1, 10, 5}, '{2, 10, 3},
    '{4, 23, 4},  '{3, 8, 2},  '{7, 40, 5}
  };

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0;
    count_in = 1'b0; cap_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 reset state
    rd(4'h2, v); chk("R9 count", v, 0);
    rd(4'h0, v); chk("R9 ctrl", v, 0);
    chk("R9 match_out", {28'd0, match_out}, 0);
    chk("R9 dma_req", {28'd0, dma_req}, 0);
    chk("R9 irq", {31'd0, irq}, 0);

    // R1 prescaled counting, table driven
    for (int k = 0; k < 6; k++) begin
      wr(4'h0, 0);
      wr(4'h1, VEC[k][0]);
      wr(4'h2, 0);
      wr(4'h0, 1);
      repeat (VEC[k][1]) @(negedge clk);
      rd(4'h2, v); chk($sformatf("R1 vector %0d", k), v, VEC[k][2]);
    end
    wr(4'h0, 0);

    // R3 reset action with R6 interrupt flag
    wr(4'h1, 0);
    wr(4'h8, 5);
    wr(4'h3, 32'h12);
    wr(4'h2, 0);
    wr(4'h0, 1);
    repeat (6) @(negedge clk);
    rd(4'h2, v); chk("R3 reset to zero", v, 0);
    @(negedge clk);
    rd(4'h2, v); chk("R3 counts on after reset", v, 1);
    wr(4'h0, 0);
    rd(4'h5, v); chk("R6 match flag set", v, 32'h1);
    chk("R6 irq high", {31'd0, irq}, 1);
    wr(4'h5, 0);
    rd(4'h5, v); chk("R6 zero write ignored", v, 32'h1);
    wr(4'h5, 1);
    rd(4'h5, v); chk("R6 one write clears", v, 0);
    chk("R6 irq low", {31'd0, irq}, 0);

    // R4 pin actions
    wr(4'h8, 5); wr(4'h9, 3); wr(4'hA, 3); wr(4'hB, 3);
    wr(4'h3, 32'h04080C02);
    wr(4'h2, 0);
    wr(4'h6, 32'h8);
    rd(4'h6, v); chk("R4 pins written", v, 32'h8);
    wr(4'h0, 1);
    repeat (4) @(negedge clk);
    chk("R4 first hit", {28'd0, match_out}, 32'h6);
    repeat (6) @(negedge clk);
    chk("R4 second hit toggles", {28'd0, match_out}, 32'h4);
    wr(4'h0, 0);

    // R3 stop action
    wr(4'h8, 7);
    wr(4'h3, 32'h01);
    wr(4'h2, 0);
    wr(4'h0, 1);
    repeat (20) @(negedge clk);
    rd(4'h2, v); chk("R3 stop holds value", v, 7);
    rd(4'h0, v); chk("R3 stop clears run", v, 0);

    // R7 DMA pulse and R3 continue
    wr(4'h8, 4);
    wr(4'h3, 32'h20);
    wr(4'h2, 0);
    wr(4'h0, 1);
    repeat (4) @(negedge clk);
    chk("R7 no request before hit", {28'd0, dma_req}, 0);
    @(negedge clk);
    chk("R7 request after hit", {28'd0, dma_req}, 1);
    @(negedge clk);
    chk("R7 request one cycle", {28'd0, dma_req}, 0);
    rd(4'h2, v); chk("R3 continue counts through", v, 6);
    wr(4'h0, 0);
    wr(4'h5, 32'hFF);

    // R5 capture with edge selection
    wr(4'h2, 123);
    wr(4'h4, 32'h0000_0205);
    cap_in = 4'b0011;
    repeat (3) @(negedge clk);
    rd(4'hC, v); chk("R5 rising capture", v, 123);
    rd(4'hD, v); chk("R5 falling-only ignores rise", v, 0);
    rd(4'h5, v); chk("R6 capture flag", v, 32'h10);
    wr(4'h2, 77);
    cap_in = 4'b0000;
    repeat (3) @(negedge clk);
    rd(4'hD, v); chk("R5 falling capture", v, 77);
    rd(4'hC, v); chk("R5 rising-only ignores fall", v, 123);
    rd(4'h5, v); chk("R6 no flag without enable", v, 32'h10);
    wr(4'h5, 32'hFF);

    // R8 pulse width with clear on capture
    wr(4'h3, 0);
    wr(4'h4, 32'h0201_0000);
    wr(4'h1, 0);
    wr(4'h2, 0);
    wr(4'h0, 32'h51);
    repeat (5) @(negedge clk);
    cap_in = 4'b1100;
    repeat (9) @(negedge clk);
    cap_in = 4'b0000;
    repeat (4) @(negedge clk);
    rd(4'hF, v); chk("R8 width prescale 0", v, 8);
    wr(4'h0, 32'h50);
    wr(4'h1, 1);
    wr(4'h2, 0);
    wr(4'h0, 32'h51);
    repeat (3) @(negedge clk);
    cap_in = 4'b1100;
    repeat (11) @(negedge clk);
    cap_in = 4'b0000;
    repeat (4) @(negedge clk);
    rd(4'hF, v); chk("R8 width prescale 1", v, 5);
    wr(4'h0, 0);

    // R2 counter mode
    wr(4'h2, 0);
    wr(4'h0, 32'h07);
    for (int p = 0; p < 5; p++) begin
      count_in = 1'b1; repeat (2) @(negedge clk);
      count_in = 1'b0; repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    rd(4'h2, v); chk("R2 rising edges", v, 5);
    wr(4'h0, 32'h0F);
    wr(4'h2, 0);
    for (int p = 0; p < 3; p++) begin
      count_in = 1'b1; repeat (2) @(negedge clk);
      count_in = 1'b0; repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    rd(4'h2, v); chk("R2 both edges", v, 6);

    finish_run();
  end
endmodule